// File: doc/BRIEF.md
# Cartridge Slot Work-RAM Write Snooper

This block listens to a console CPU bus at the cartridge slot without ever driving it. It reports each CPU write that targets the internal 2 KB work RAM. All slot signals are oversampled by a system clock that runs at least eight times faster than the bus phase clock M2. The slot has no A15 pin. The block rebuilds A15 from the active-low ROM select line, which is the NAND of M2 and A15 and changes about 20 ns after M2 does. Because of that lag, the ROM select level still shows the ending cycle's A15 at the moment M2 falls.

Each bus cycle is judged on its own when M2 falls. The cycle is reported when it is a write (R/W low), the rebuilt A15 is zero and A14..A13 are zero. The address is then folded onto the 2 KB RAM, and the 11-bit offset and the data byte go into a small FIFO. A downstream consumer drains the FIFO through a valid/ready pair. A sticky flag records that a capture was lost because the FIFO was full.

Top module: `cart_wr_snoop`

## Requirements
- R1: A15 is taken as 1 when ROM select is low in the last synchronized sample before M2 falls. Such cycles are never reported, and ROM select high gives A15 = 0.
- R2: Cycles with R/W high (reads) are never reported.
- R3: A cycle is reported only when A14 and A13 are both 0. Addresses 0x2000–0x7FFF with A15 = 0 are not reported.
- R4: The reported offset is A10..A0. A12 and A11 are ignored, so every mirror of a RAM location gives the same offset.
- R5: The reported data and address are the values present just before M2 falls. Data that is changed earlier in the high phase, or after the fall, has no effect.
- R6: Each qualifying M2 fall produces exactly one record, and records leave in bus order. Two records never enter the FIFO on consecutive clocks.
- R7: A record stays on `rec_offset_o`/`rec_data_o` with `rec_valid_o` high, unchanged, until `rec_ready_i` is high.
- R8: The FIFO holds FIFO_DEPTH records. A capture that arrives while the FIFO is full is dropped, and `overflow_o` sets and stays set until reset.
- R9: Reset empties the FIFO and clears `overflow_o` (both outputs read 0). An M2 fall that coincides with reset release produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m2_i | input | 1 | Bus phase clock from the slot |
| addr_i | input | 15 | Slot address A14..A0 |
| data_i | input | 8 | Slot data D7..D0 |
| rnw_i | input | 1 | Read/not-write, low for a CPU write |
| romsel_n_i | input | 1 | Active-low ROM select (NAND of M2 and A15) |
| rec_valid_o | output | 1 | A captured record is available |
| rec_ready_i | input | 1 | Consumer accepts the record this clock |
| rec_offset_o | output | 11 | Work-RAM offset A10..A0 of the record |
| rec_data_o | output | 8 | Data byte written by the CPU |
| overflow_o | output | 1 | Sticky flag: a capture was dropped on a full FIFO |

## Verification
The embedded properties check the following on every clock: capture pulses never come back to back, the delayed bus copy shows M2 high whenever a capture is raised, a stalled record holds steady, FIFO occupancy stays within its depth, and the overflow flag never clears on its own. Whether a given bus cycle is decoded correctly (A15 rebuilt from the lagging ROM select, read/ROM/I-O filtering, mirror folding, and the data byte taken at the fall rather than earlier or later) can only be shown by the bench's sweeps. These sweeps cover address, direction and A15 combinations, with a reference queue computed from the bus stimulus. The bench scenarios also cover dropping on a full FIFO and the reset-release corner.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int unsigned ADDR_W = 15;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFF_W  = 11;

  typedef struct packed {
    logic              m2;
    logic              rnw;
    logic              romsel_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_s;

  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] data;
  } rec_s;

  localparam int unsigned BUS_W = $bits(bus_s);
  localparam int unsigned REC_W = $bits(rec_s);
endpackage

// File: rtl/cws_sync.sv
module cws_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cws_decode.sv
module cws_decode
  import cws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  bus_s smp_i,
  output logic cap_valid_o,
  output rec_s cap_rec_o
);
  logic m2_prev_q, m2_prev_d;
  bus_s bus_q, bus_d;
  logic fall, a15_rec, in_ram;

  always_comb begin
    m2_prev_d = smp_i.m2;
    bus_d     = smp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m2_prev_q <= 1'b0;
      bus_q     <= '0;
    end else begin
      m2_prev_q <= m2_prev_d;
      bus_q     <= bus_d;
    end
  end

  always_comb begin
    fall        = m2_prev_q & ~smp_i.m2;
    a15_rec     = ~bus_q.romsel_n;
    in_ram      = (bus_q.addr[14:13] == 2'b00);
    cap_valid_o = fall & ~bus_q.rnw & ~a15_rec & in_ram;
    cap_rec_o.off  = bus_q.addr[OFF_W-1:0];
    cap_rec_o.data = bus_q.data;
  end

  AST_ONE_PER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid_o |=> !cap_valid_o); // R6
  AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid_o |-> bus_q.m2); // R5
endmodule

// File: rtl/cws_fifo.sv
module cws_fifo #(
  parameter int unsigned W     = 19,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic         rd_valid_o,
  input  logic         rd_ready_i,
  output logic [W-1:0] rd_data_o,
  output logic         overflow_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             full, push, pop;

  always_comb begin
    full     = (cnt_q == FULL_CNT);
    push     = wr_en_i & ~full;
    pop      = rd_valid_o & rd_ready_i;
    wr_ptr_d = push ? ((wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1) : wr_ptr_q;
    rd_ptr_d = pop  ? ((rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1) : rd_ptr_q;
    cnt_d    = cnt_q + CNT_W'(push) - CNT_W'(pop);
    ovf_d    = ovf_q | (wr_en_i & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= wr_data_i;
  end

  assign rd_valid_o = (cnt_q != '0);
  assign rd_data_o  = mem_q[rd_ptr_q];
  assign overflow_o = ovf_q;

  AST_OCCUPANCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R8
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o); // R8
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o)); // R7
endmodule

// File: rtl/cart_wr_snoop.sv
module cart_wr_snoop
  import cws_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FIFO_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rnw_i,
  input  logic              romsel_n_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [OFF_W-1:0]  rec_offset_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic              overflow_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bus_s raw_bus, smp_bus;
  logic [BUS_W-1:0] smp_vec;
  logic cap_valid;
  rec_s cap_rec, out_rec;
  logic [REC_W-1:0] out_vec;

  assign raw_bus = '{m2: m2_i, rnw: rnw_i, romsel_n: romsel_n_i, addr: addr_i, data: data_i};

  cws_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(raw_bus), .q_o(smp_vec)
  );
  assign smp_bus = bus_s'(smp_vec);

  cws_decode u_decode (
    .clk(clk), .rst_n(rst_int_n), .smp_i(smp_bus),
    .cap_valid_o(cap_valid), .cap_rec_o(cap_rec)
  );

  cws_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en_i(cap_valid), .wr_data_i(cap_rec),
    .rd_valid_o(rec_valid_o), .rd_ready_i(rec_ready_i),
    .rd_data_o(out_vec), .overflow_o(overflow_o)
  );

  assign out_rec      = rec_s'(out_vec);
  assign rec_offset_o = out_rec.off;
  assign rec_data_o   = out_rec.data;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> !rec_valid_o && !overflow_o); // R9
endmodule

// File: tb/cart_wr_snoop_bench.sv
`timescale 1ns/1ps
module cart_wr_snoop_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m2_i, rnw_i, romsel_n_i, rec_ready_i;
  logic [14:0] addr_i;
  logic [7:0]  data_i;
  logic        rec_valid_o, overflow_o;
  logic [10:0] rec_offset_o;
  logic [7:0]  rec_data_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  int model_cnt = 0;
  bit model_ovf = 0;
  logic [18:0] exp_q [$];

  always #2 clk = ~clk;

  cart_wr_snoop #(.FIFO_DEPTH(DEPTH)) u_cart_wr_snoop (
    .clk(clk), .rst_n(rst_n), .m2_i(m2_i), .addr_i(addr_i), .data_i(data_i),
    .rnw_i(rnw_i), .romsel_n_i(romsel_n_i), .rec_valid_o(rec_valid_o),
    .rec_ready_i(rec_ready_i), .rec_offset_o(rec_offset_o),
    .rec_data_o(rec_data_o), .overflow_o(overflow_o)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Consumer side: compare every accepted record with the reference queue (R4, R5, R6)
  always @(negedge clk) begin
    if (rst_n && rec_valid_o && rec_ready_i) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected record", {rec_offset_o, rec_data_o}, 0);
      end else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        check({rec_offset_o, rec_data_o} == e, "R4/R5 record", {rec_offset_o, rec_data_o}, e);
      end
      if (model_cnt > 0) model_cnt--;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
      finish_run();
    end
  end

  // One CPU bus cycle: low phase, high phase with lagging ROM select, fall, hold, junk.
  task automatic bus_cycle(input bit a15, input logic [14:0] a, input logic [7:0] d, input bit rnw);
    addr_i = a; rnw_i = rnw; data_i = ~d;
    #280 m2_i = 1'b1;
    #20  romsel_n_i = ~a15;
    #180 data_i = d;
    #80  m2_i = 1'b0;
    if (!rnw && !a15 && a[14:13] == 2'b00) begin
      if (model_cnt < DEPTH) begin
        exp_q.push_back({a[10:0], d});
        model_cnt++;
      end else model_ovf = 1;
    end
    #20  romsel_n_i = 1'b1;
    #4   addr_i = ~a; data_i = d ^ 8'h5A; rnw_i = ~rnw;
  endtask

  initial begin
    rst_n = 0; m2_i = 1; rnw_i = 0; romsel_n_i = 1; addr_i = 15'h0010;
    data_i = 8'h55; rec_ready_i = 1;
    #40;
    check(rec_valid_o == 0, "R9 valid in reset", rec_valid_o, 0);
    check(overflow_o == 0, "R9 overflow in reset", overflow_o, 0);
    @(negedge clk); rst_n = 1; m2_i = 0;
    repeat (40) @(negedge clk);
    check(rec_valid_o == 0, "R9 fall at reset release", rec_valid_o, 0);
    rnw_i = 1;

    // Sweep of A15, direction and address classes (R1, R2, R3)
    for (int i = 0; i < 64; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic [14:0] a;
        a = 15'((i * 32'h0209 + c * 32'h1357) & 32'h7FFF);
        bus_cycle(c[0], a, 8'((i * 37 + c * 11) & 8'hFF), c[1]);
      end
    end
    // Dense in-region writes (R3, R5)
    for (int i = 0; i < 32; i++)
      bus_cycle(1'b0, 15'((i * 32'h00FB) & 32'h1FFF), 8'(i * 7 + 3), 1'b0);
    // Mirrors of the same offsets (R4)
    for (int k = 0; k < 8; k++)
      for (int m = 0; m < 4; m++)
        bus_cycle(1'b0, {2'b00, 2'(m), 11'(k * 32'h0123 + 5)}, 8'(k * 16 + m), 1'b0);
    // ROM-region and I/O-region writes never produce a record (R1, R3)
    bus_cycle(1'b1, 15'h0000, 8'hA1, 1'b0);
    bus_cycle(1'b0, 15'h2000, 8'hA2, 1'b0);
    bus_cycle(1'b0, 15'h7FFF, 8'hA3, 1'b0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6 all records drained", exp_q.size(), 0);
    check(overflow_o == 0, "R8 no overflow while draining", overflow_o, 0);

    // Stall consumer and overfill (R7, R8)
    rec_ready_i = 0;
    for (int i = 0; i < DEPTH + 2; i++)
      bus_cycle(1'b0, 15'(32'h0040 + i), 8'(8'hC0 + i), 1'b0);
    repeat (10) @(negedge clk);
    check(rec_valid_o == 1, "R7 valid held while stalled", rec_valid_o, 1);
    check(rec_offset_o == 11'h040, "R7 head offset held", rec_offset_o, 11'h040);
    check(rec_data_o == 8'hC0, "R7 head data held", rec_data_o, 8'hC0);
    check(overflow_o == model_ovf, "R8 overflow set", overflow_o, model_ovf);
    rec_ready_i = 1;
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R8 only first DEPTH kept", exp_q.size(), 0);
    check(rec_valid_o == 0, "R8 empty after drain", rec_valid_o, 0);
    check(overflow_o == 1, "R8 overflow sticky", overflow_o, 1);

    // Reset clears overflow (R9)
    rst_n = 0; model_ovf = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(overflow_o == 0, "R9 overflow cleared", overflow_o, 0);
    bus_cycle(1'b0, 15'h1ABC, 8'h3C, 1'b0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4 capture after reset", exp_q.size(), 0);
    finish_run();
  end
endmodule